// File: doc/BRIEF.md
# PCI Write Packing Buffer

This block sits between a PCI target's write path and the memory controller. The PCI side delivers write beats. Each beat is one 32-bit word with its word address, four byte enables and a flag that marks the final beat of a burst. The block steers each beat onto the correct half of a 64-bit doubleword. Beats that land in the same doubleword are merged, so the memory controller sees only doubleword-aligned writes, each with an 8-bit byte mask.

Storage is four doubleword slots, 32 bytes in total. At most one slot is open and still gathering bytes. A doubleword is handed to memory in two cases: the next beat addresses a different doubleword, or the burst ends. Writes are buffered, not posted. The requester learns that a burst has completed only after memory has accepted the doubleword that carries the burst's final beat. Because of this, processor traffic never has to look inside the buffer.

Top module: `pci_wr_packer`

## Requirements
- R1: After reset, `mem_valid` is 0, `wr_done` is 0 and `in_ready` is 1.
- R2: `in_waddr` is a 32-bit-word address. Bit 0 selects the half of the doubleword: 0 is byte lanes 0-3 and 1 is lanes 4-7. Input byte k, held in `in_data[8k+7:8k]` and enabled by `in_be[k]`, goes to lane 4·half+k. The lane order is little-endian. `mem_addr` equals `in_waddr[29:1]`.
- R3: Beats accepted while one doubleword is open merge into a single request. The request's mask is the OR of the beats' enables. Where two beats enable the same byte, the later beat's value wins.
- R4: A beat whose doubleword differs from the open one first commits the open doubleword as a request, then opens a new doubleword.
- R5: A beat with `in_last` set commits its doubleword, even a partial one, in the same cycle it is accepted. `mem_valid` is high on the next cycle.
- R6: In every request, `mem_be` marks only the bytes that were written, and every byte lane whose mask bit is 0 carries zero.
- R7: Requests reach memory in the order their doublewords were committed.
- R8: While `mem_valid` is high and `mem_ready` is low, the request (`mem_valid`, `mem_addr`, `mem_data`, `mem_be`) holds unchanged on the next cycle.
- R9: Committed slots plus the open slot never exceed four. `in_ready` is 0 whenever four committed doublewords are waiting for memory. It is also 0 when three are waiting, one is open, and the presented beat needs a new doubleword. A beat for the open doubleword is still taken in that case.
- R10: `wr_done` is high for exactly one cycle, the cycle after memory accepts a request that carries a burst's final beat. It stays low while that request waits.
- R11: An open doubleword that has not been committed is never presented to memory.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Write beat present |
| in_ready | output | 1 | Beat accepted on this edge when valid |
| in_waddr | input | 30 | Word address of the beat |
| in_data | input | 32 | Beat data, little-endian bytes |
| in_be | input | 4 | Byte enables of the beat |
| in_last | input | 1 | Final beat of the burst |
| mem_valid | output | 1 | Doubleword write request pending |
| mem_ready | input | 1 | Memory accepts the request on this edge |
| mem_addr | output | 29 | Doubleword address |
| mem_data | output | 64 | Merged doubleword data |
| mem_be | output | 8 | Byte mask of the request |
| wr_done | output | 1 | Burst completed into memory |

## Verification
Two things can happen in one cycle: a commit from the input side, and a pop from the memory side. A further case is a single beat that both flushes the old doubleword and ends its own burst, which adds two slots at once. The bench provokes the commit-and-pop collision by holding `mem_ready` low with one request waiting. It then releases `mem_ready` at the same edge where a final beat is accepted. The result is judged by the order and content of the recorded requests, by the count of completion pulses, and by memory going idle with nothing left behind. Occupancy at the stall limit is exercised both with four committed slots and with three committed slots plus an open one.

// File: rtl/pwb_pkg.sv
package pwb_pkg;

    localparam int ADDR_W    = 32;
    localparam int IN_BYTES  = 4;
    localparam int DW_BYTES  = 8;
    localparam int IN_BITS   = IN_BYTES * 8;
    localparam int DW_BITS   = DW_BYTES * 8;
    localparam int LANE_GRPS = DW_BYTES / IN_BYTES;
    localparam int GRP_W     = $clog2(LANE_GRPS);
    localparam int IN_OFS_W  = $clog2(IN_BYTES);
    localparam int DW_OFS_W  = $clog2(DW_BYTES);
    localparam int WA_W      = ADDR_W - IN_OFS_W;
    localparam int DWA_W     = ADDR_W - DW_OFS_W;

    typedef logic [DWA_W-1:0]    dwaddr_t;
    typedef logic [DW_BITS-1:0]  dwdata_t;
    typedef logic [DW_BYTES-1:0] dwmask_t;

    typedef struct packed {
        dwaddr_t dwa;
        dwdata_t data;
        dwmask_t be;
        logic    last;
    } slot_t;

    function automatic dwaddr_t dw_of(input logic [WA_W-1:0] waddr);
        return waddr[WA_W-1:GRP_W];
    endfunction

    function automatic logic [GRP_W-1:0] grp_of(input logic [WA_W-1:0] waddr);
        return waddr[GRP_W-1:0];
    endfunction

endpackage

// File: rtl/pwb_merge.sv
module pwb_merge
    import pwb_pkg::*;
(
    input  dwdata_t                base_data,
    input  dwmask_t                base_be,
    input  logic                   fresh,
    input  logic [GRP_W-1:0]       grp,
    input  logic [IN_BITS-1:0]     beat_data,
    input  logic [IN_BYTES-1:0]    beat_be,
    output dwdata_t                out_data,
    output dwmask_t                out_be
);

    for (genvar j = 0; j < DW_BYTES; j++) begin : g_lane
        localparam int GIDX = j / IN_BYTES;
        localparam int KIDX = j % IN_BYTES;
        logic take;
        assign take = (grp == GRP_W'(GIDX)) && beat_be[KIDX];
        assign out_data[j*8 +: 8] = take  ? beat_data[KIDX*8 +: 8] :
                                    fresh ? 8'h00 : base_data[j*8 +: 8];
        assign out_be[j] = take || (!fresh && base_be[j]);
    end

endmodule

// File: rtl/pwb_ring.sv
module pwb_ring
    import pwb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  slot_t            wslot,
    input  logic [IDX_W-1:0] open_idx,
    output dwaddr_t          open_dwa,
    output dwdata_t          open_data,
    output dwmask_t          open_be,
    input  logic [IDX_W-1:0] head_idx,
    output slot_t            head
);

    slot_t store_q [SLOTS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) store_q[i] <= '0;
        end else if (we) begin
            store_q[widx] <= wslot;
        end
    end

    assign open_dwa  = store_q[open_idx].dwa;
    assign open_data = store_q[open_idx].data;
    assign open_be   = store_q[open_idx].be;
    assign head      = store_q[head_idx];

endmodule

// File: rtl/pci_wr_packer.sv
module pci_wr_packer
    import pwb_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [WA_W-1:0]     in_waddr,
    input  logic [IN_BITS-1:0]  in_data,
    input  logic [IN_BYTES-1:0] in_be,
    input  logic                in_last,
    output logic                mem_valid,
    input  logic                mem_ready,
    output logic [DWA_W-1:0]    mem_addr,
    output logic [DW_BITS-1:0]  mem_data,
    output logic [DW_BYTES-1:0] mem_be,
    output logic                wr_done
);

    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;
    localparam int CNT_W = $clog2(SLOTS + 1);

    function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
        return (p == IDX_W'(SLOTS - 1)) ? '0 : p + IDX_W'(1);
    endfunction

    logic [IDX_W-1:0] wr_q, rd_q, tgt;
    logic [CNT_W-1:0] cnt_q;
    logic             open_q, done_q;

    dwaddr_t open_dwa, beat_dwa;
    dwdata_t open_data, mrg_data;
    dwmask_t open_be, mrg_be;
    slot_t   head_s, new_s;

    logic       same, need_new, acc, pop;
    logic [1:0] commit_n;

    assign beat_dwa = dw_of(in_waddr);
    assign same     = open_q && (open_dwa == beat_dwa);
    assign need_new = open_q && !same;
    assign in_ready = same || ((int'(cnt_q) + int'(open_q)) < SLOTS);
    assign acc      = in_valid && in_ready;
    assign tgt      = need_new ? step(wr_q) : wr_q;
    assign commit_n = acc ? ({1'b0, need_new} + {1'b0, in_last}) : 2'd0;
    assign pop      = (cnt_q != '0) && mem_ready;

    pwb_merge u_merge (
        .base_data (open_data),
        .base_be   (open_be),
        .fresh     (!same),
        .grp       (grp_of(in_waddr)),
        .beat_data (in_data),
        .beat_be   (in_be),
        .out_data  (mrg_data),
        .out_be    (mrg_be)
    );

    always_comb begin
        new_s.dwa  = beat_dwa;
        new_s.data = mrg_data;
        new_s.be   = mrg_be;
        new_s.last = in_last;
    end

    pwb_ring #(.SLOTS(SLOTS)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .we        (acc),
        .widx      (tgt),
        .wslot     (new_s),
        .open_idx  (wr_q),
        .open_dwa  (open_dwa),
        .open_data (open_data),
        .open_be   (open_be),
        .head_idx  (rd_q),
        .head      (head_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_q   <= '0;
            rd_q   <= '0;
            cnt_q  <= '0;
            open_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            if (acc) begin
                wr_q   <= in_last ? step(tgt) : tgt;
                open_q <= !in_last;
            end
            if (pop) rd_q <= step(rd_q);
            cnt_q  <= cnt_q + CNT_W'(commit_n) - CNT_W'(pop);
            done_q <= pop && head_s.last;
        end
    end

    assign mem_valid = (cnt_q != '0);
    assign mem_addr  = head_s.dwa;
    assign mem_data  = head_s.data;
    assign mem_be    = head_s.be;
    assign wr_done   = done_q;

endmodule

// File: rtl/pci_wr_packer_chk.sv
module pci_wr_packer_chk
    import pwb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input logic                clk,
    input logic                rst,
    input logic                in_valid,
    input logic                in_ready,
    input logic                in_last,
    input logic                mem_valid,
    input logic                mem_ready,
    input logic [DWA_W-1:0]    mem_addr,
    input logic [DW_BITS-1:0]  mem_data,
    input logic [DW_BYTES-1:0] mem_be,
    input logic                wr_done,
    input logic [CNT_W-1:0]    cnt,
    input logic                open
);

    logic [DW_BYTES-1:0] dirty_lane;
    always_comb begin
        for (int j = 0; j < DW_BYTES; j++)
            dirty_lane[j] = !mem_be[j] && (mem_data[j*8 +: 8] != 8'h00);
    end

    assert_last_flush_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && in_last) |=> mem_valid);

    assert_zero_lanes_R6: assert property (@(posedge clk) disable iff (rst)
        mem_valid |-> (dirty_lane == '0));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr)
                                       && $stable(mem_data) && $stable(mem_be)));

    assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
        (int'(cnt) + int'(open)) <= SLOTS);

    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        wr_done |-> $past(mem_valid && mem_ready));

endmodule

bind pci_wr_packer pci_wr_packer_chk #(.SLOTS(SLOTS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_last   (in_last),
    .mem_valid (mem_valid),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .mem_data  (mem_data),
    .mem_be    (mem_be),
    .wr_done   (wr_done),
    .cnt       (cnt_q),
    .open      (open_q)
);

// File: tb/pci_wr_packer_tb.sv
module pci_wr_packer_tb;
    import pwb_pkg::*;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                in_valid = 1'b0;
    logic                in_ready;
    logic [WA_W-1:0]     in_waddr = '0;
    logic [IN_BITS-1:0]  in_data = '0;
    logic [IN_BYTES-1:0] in_be = '0;
    logic                in_last = 1'b0;
    logic                mem_valid;
    logic                mem_ready = 1'b0;
    logic [DWA_W-1:0]    mem_addr;
    logic [DW_BITS-1:0]  mem_data;
    logic [DW_BYTES-1:0] mem_be;
    logic                wr_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;
    int rec_n = 0;
    bit stall = 1'b0;
    logic [63:0] rec_addr [32];
    logic [63:0] rec_data [32];
    logic [63:0] rec_be   [32];

    always #5 clk = ~clk;

    pci_wr_packer u_dut (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_ready(in_ready), .in_waddr(in_waddr),
        .in_data(in_data), .in_be(in_be), .in_last(in_last),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_be(mem_be), .wr_done(wr_done)
    );

    // memory model: ready set at negedge, acceptance recorded for next edge
    always @(negedge clk) begin
        mem_ready = !stall;
        #1;
        if (!rst && mem_valid && mem_ready && rec_n < 32) begin
            rec_addr[rec_n] = 64'(mem_addr);
            rec_data[rec_n] = mem_data;
            rec_be[rec_n]   = 64'(mem_be);
            rec_n++;
        end
        if (!rst && wr_done) done_cnt++;
    end

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic chk_req(input string req, input int i, input logic [63:0] a,
                           input logic [63:0] d, input logic [63:0] b);
        chk(req, "request present", 64'(i < rec_n), 64'd1);
        if (i < rec_n) begin
            chk(req, "mem_addr", rec_addr[i], a);
            chk(req, "mem_data", rec_data[i], d);
            chk(req, "mem_be",   rec_be[i],   b);
        end
    endtask

    task automatic send(input logic [31:0] byte_addr, input logic [31:0] d,
                        input logic [3:0] be, input bit last);
        @(negedge clk);
        in_valid = 1'b1;
        in_waddr = WA_W'(byte_addr >> 2);
        in_data  = d;
        in_be    = be;
        in_last  = last;
        #2;
        while (!in_ready) begin
            @(negedge clk);
            #2;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic drain();
        stall = 1'b0;
        repeat (20) @(negedge clk);
        #3;
    endtask

    task automatic t_reset();
        @(negedge clk);
        #3;
        chk("R1", "mem_valid after reset", 64'(mem_valid), 64'd0);
        chk("R1", "wr_done after reset",   64'(wr_done),   64'd0);
        chk("R1", "in_ready after reset",  64'(in_ready),  64'd1);
    endtask

    task automatic t_single_byte();
        int b = rec_n, d0 = done_cnt;
        send(32'h1005, 32'h0000AB00, 4'b0010, 1'b1);
        drain();
        chk_req("R2", b, 64'h200, 64'h0000AB00_00000000, 64'h20);
        chk("R6", "request count", 64'(rec_n - b), 64'd1);
        chk("R10", "done pulses", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_merge();
        int b = rec_n;
        send(32'h2000, 32'h11223344, 4'hF, 1'b0);
        send(32'h2004, 32'h55667788, 4'h3, 1'b0);
        send(32'h2000, 32'h000000EE, 4'h1, 1'b1);
        drain();
        chk("R3", "merged into one request", 64'(rec_n - b), 64'd1);
        chk_req("R3", b, 64'h400, 64'h00007788_112233EE, 64'h3F);
    endtask

    task automatic t_dw_change();
        int b = rec_n, d0 = done_cnt;
        send(32'h3000, 32'hA1A2A3A4, 4'hF, 1'b0);
        send(32'h3008, 32'hB1B2B3B4, 4'hF, 1'b1);
        drain();
        chk("R4", "two requests", 64'(rec_n - b), 64'd2);
        chk_req("R4", b,     64'h600, 64'h00000000_A1A2A3A4, 64'h0F);
        chk_req("R7", b + 1, 64'h601, 64'h00000000_B1B2B3B4, 64'h0F);
        chk("R10", "one pulse per burst", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_partial_last();
        int b = rec_n, d0 = done_cnt;
        send(32'h4004, 32'hCAFEBABE, 4'hF, 1'b0);
        repeat (5) @(negedge clk);
        #3;
        chk("R11", "open doubleword not presented", 64'(mem_valid), 64'd0);
        chk("R11", "no request recorded", 64'(rec_n - b), 64'd0);
        stall = 1'b1;
        send(32'h4000, 32'h12345678, 4'b1100, 1'b1);
        repeat (5) @(negedge clk);
        #3;
        chk("R5", "partial committed on last", 64'(mem_valid), 64'd1);
        chk("R10", "no done while waiting", 64'(done_cnt - d0), 64'd0);
        drain();
        chk_req("R5", b, 64'h800, 64'hCAFEBABE_12340000, 64'hFC);
        chk("R10", "done after accept", 64'(done_cnt - d0), 64'd1);
    endtask

    task automatic t_full();
        int b = rec_n, d0 = done_cnt;
        stall = 1'b1;
        for (int k = 0; k < 4; k++)
            send(32'h5000 + 32'(k * 8), 32'h0A0B0C00 + 32'(k), 4'hF, 1'b1);
        @(negedge clk);
        in_valid = 1'b1;
        in_waddr = WA_W'(32'h5020 >> 2);
        in_data  = 32'hDEADBEEF;
        in_be    = 4'hF;
        in_last  = 1'b1;
        #2;
        chk("R9", "ready low with four waiting", 64'(in_ready), 64'd0);
        repeat (3) @(negedge clk);
        #2;
        chk("R9", "ready still low", 64'(in_ready), 64'd0);
        in_valid = 1'b0;
        drain();
        chk("R9", "four requests", 64'(rec_n - b), 64'd4);
        for (int k = 0; k < 4; k++)
            chk_req("R7", b + k, 64'hA00 + 64'(k),
                    {32'h0, 32'h0A0B0C00 + 32'(k)}, 64'h0F);
        chk("R10", "four pulses", 64'(done_cnt - d0), 64'd4);
    endtask

    task automatic t_three_plus_open();
        int b = rec_n;
        stall = 1'b1;
        for (int k = 0; k < 3; k++)
            send(32'h7000 + 32'(k * 8), 32'h70000000 + 32'(k), 4'hF, 1'b1);
        send(32'h7018, 32'h99887766, 4'hF, 1'b0);
        @(negedge clk);
        in_valid = 1'b1;
        in_waddr = WA_W'(32'h7020 >> 2);
        in_be    = 4'hF;
        in_last  = 1'b1;
        #2;
        chk("R9", "ready low for new doubleword", 64'(in_ready), 64'd0);
        in_waddr = WA_W'(32'h701C >> 2);
        #1;
        chk("R9", "ready high for open doubleword", 64'(in_ready), 64'd1);
        in_valid = 1'b0;
        send(32'h701C, 32'h44332211, 4'hF, 1'b1);
        drain();
        chk("R9", "four requests", 64'(rec_n - b), 64'd4);
        chk_req("R3", b + 3, 64'hE03, 64'h44332211_99887766, 64'hFF);
    endtask

    task automatic t_collision();
        int b = rec_n, d0 = done_cnt;
        stall = 1'b1;
        send(32'h8000, 32'h0000C0DE, 4'h3, 1'b1);
        stall = 1'b0;
        send(32'h8008, 32'hF00D0000, 4'hC, 1'b1);
        repeat (6) @(negedge clk);
        #3;
        chk("R7", "both requests", 64'(rec_n - b), 64'd2);
        chk_req("R7", b,     64'h1000, 64'h00000000_0000C0DE, 64'h03);
        chk_req("R7", b + 1, 64'h1001, 64'h00000000_F00D0000, 64'h0C);
        chk("R10", "two pulses", 64'(done_cnt - d0), 64'd2);
        chk("R7", "idle after collision", 64'(mem_valid), 64'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_single_byte();
        t_merge();
        t_dw_change();
        t_partial_last();
        t_full();
        t_three_plus_open();
        t_collision();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL all watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule